// File: doc/BRIEF.md
# Programming-Status Read Multiplexer

This block chooses what a byte-wide memory model puts on its read bus. While no programming cycle is running, an enabled read returns the array word unchanged. While a programming cycle is running, the two top bits of every read carry status instead of stored data, so a host can poll until the cycle finishes.

The most significant bit returns the complement of the top bit of the last byte loaded. The next bit down changes value once per completed read. The write controller supplies the busy flag and that top bit. The bus pins supply the strobes.

The output bus is modelled as a data vector plus a drive-enable. When the drive-enable is low, the data vector reads as zero and stands for a released bus. Electrical tristate behaviour and bus timing in nanoseconds are not modelled.

Top module: `poll_read_mux`

## Requirements
- R1: `doutEn` is 1 exactly when `resN` is 1, `ceN` is 0, `oeN` is 0 and `weN` is 1, evaluated in the same cycle with no register on the path.
- R2: Whenever `doutEn` is 0, `dout` is all zeros.
- R3: With `busy` at 0 and `doutEn` at 1, `dout` equals `arrayData` in every bit.
- R4: With `busy` at 1 and `doutEn` at 1, `dout` bit 7 (the most significant) equals the inverse of `lastTopBit`.
- R5: The first read that begins after `busy` rises returns 1 in `dout` bit 6.
- R6: While `busy` is 1, each read that ends inverts the bit 6 value returned by the next read. A read ends at a clock edge where the read was active at the previous edge and is inactive now. Clock edges without a read ending leave bit 6 unchanged.
- R7: Within one continuous read during `busy`, bit 6 of `dout` holds its value from cycle to cycle.
- R8: A 0 on `resN` releases the bus (`doutEn` at 0), whatever the other strobes are.
- R9: After `rstN` is released, the first read during `busy` returns 1 in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous block reset |
| resN | input | 1 | Active-low protection input; low releases the bus |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| busy | input | 1 | Programming cycle in progress, from the write controller |
| lastTopBit | input | 1 | Most significant bit of the last byte loaded |
| arrayData | input | DATA_W | Word read from the array |
| dout | output | DATA_W | Read data; zero while released |
| doutEn | output | 1 | Bus drive enable |

## Verification
The assertions assume that `busy` and `lastTopBit` change only between clock edges, in the same way as the strobes. They also assume that a read which should count as ended spans at least one clock edge. The bench drives every input on the falling clock edge and holds it across a full rising edge, so each read it makes is seen by at least one rising edge. The random phase changes `busy` only rarely, which leaves long polling runs in which bit 6 toggles many times.

// File: rtl/poll_read_pkg.sv
package poll_read_pkg;
  typedef struct packed {
    logic driveEn;
    logic statusSel;
    logic toggleFlip;
    logic toggleLoad;
  } readStrobes_t;
endpackage

// File: rtl/poll_read_ctrl.sv
module poll_read_ctrl
  import poll_read_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         resN,
  input  logic         ceN,
  input  logic         oeN,
  input  logic         weN,
  input  logic         busy,
  output readStrobes_t strobes
);
  logic readActive;
  logic readActiveQ;
  logic readEnd;

  assign readActive = resN & ~ceN & ~oeN & weN;
  assign readEnd    = readActiveQ & ~readActive;

  always_ff @(posedge clk) begin
    if (!rstN) readActiveQ <= 1'b0;
    else       readActiveQ <= readActive;
  end

  always_comb begin
    strobes.driveEn    = readActive;
    strobes.statusSel  = busy;
    strobes.toggleLoad = ~busy;
    strobes.toggleFlip = busy & readEnd;
  end
endmodule

// File: rtl/poll_read_dp.sv
module poll_read_dp
  import poll_read_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  readStrobes_t      strobes,
  input  logic              lastTopBit,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dout
);
  localparam int POLL_BIT   = DATA_W - 1;
  localparam int TOGGLE_BIT = DATA_W - 2;

  logic              toggleQ;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN)                   toggleQ <= 1'b1;
    else if (strobes.toggleLoad) toggleQ <= 1'b1;
    else if (strobes.toggleFlip) toggleQ <= ~toggleQ;
  end

  always_comb begin
    statusWord             = arrayData;
    statusWord[POLL_BIT]   = ~lastTopBit;
    statusWord[TOGGLE_BIT] = toggleQ;
  end

  always_comb begin
    if (!strobes.driveEn)       dout = '0;
    else if (strobes.statusSel) dout = statusWord;
    else                        dout = arrayData;
  end
endmodule

// File: rtl/poll_read_mux.sv
module poll_read_mux
  import poll_read_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              busy,
  input  logic              lastTopBit,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dout,
  output logic              doutEn
);
  readStrobes_t strobes;

  poll_read_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .resN(resN), .ceN(ceN), .oeN(oeN),
    .weN(weN), .busy(busy), .strobes(strobes)
  );

  poll_read_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lastTopBit(lastTopBit),
    .arrayData(arrayData), .dout(dout)
  );

  assign doutEn = strobes.driveEn;
endmodule

// File: rtl/poll_read_chk.sv
module poll_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              resN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              busy,
  input logic              lastTopBit,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] dout,
  input logic              doutEn
);
  // R2
  released_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doutEn |-> dout == '0);
  // R8
  res_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resN |-> !doutEn);
  // R1
  write_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!weN || ceN || oeN) |-> !doutEn);
  // R3
  array_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doutEn && !busy) |-> dout == arrayData);
  // R4
  poll_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doutEn && busy) |-> dout[DATA_W-1] == !lastTopBit);
  // R7
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doutEn && busy && $past(doutEn) && $past(busy) && $past(rstN))
      |-> $stable(dout[DATA_W-2]));
endmodule

bind poll_read_mux poll_read_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/poll_read_mux_tb.sv
module poll_read_mux_tb_top;
  localparam int DATA_W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0, resN = 1'b1, ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic busy = 1'b0, lastTopBit = 1'b0;
  logic [DATA_W-1:0] arrayData = '0;
  logic [DATA_W-1:0] dout;
  logic doutEn;

  int checks = 0;
  int errors = 0;
  logic expTog = 1'b1;
  logic prevAct = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_read_mux #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .resN(resN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .busy(busy), .lastTopBit(lastTopBit), .arrayData(arrayData),
    .dout(dout), .doutEn(doutEn)
  );

  function automatic logic readOn(logic r, logic c, logic o, logic w);
    return r & ~c & ~o & w;
  endfunction

  // bench model of the toggle bit, built from R5, R6 and R9
  always @(posedge clk) begin
    logic act;
    act = readOn(resN, ceN, oeN, weN);
    if (!rstN || !busy) expTog = 1'b1;
    else if (prevAct && !act) expTog = ~expTog;
    prevAct = rstN ? act : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    logic en;
    en = readOn(resN, ceN, oeN, weN);
    chk(doutEn == en, "R1 drive enable", doutEn, en);
    if (!resN) chk(doutEn == 1'b0, "R8 res release", doutEn, 0);
    if (!en) chk(dout == '0, "R2 released zero", dout, 0);
    else if (!busy) chk(dout == arrayData, "R3 array data", dout, arrayData);
    else begin
      chk(dout[7] == ~lastTopBit, "R4 poll bit", dout[7], ~lastTopBit);
      chk(dout[6] == expTog, "R6 toggle bit", dout[6], expTog);
    end
  endtask

  task automatic drive(input logic r, c, o, w, b, l, input logic [7:0] d);
    @(negedge clk);
    resN = r; ceN = c; oeN = o; weN = w; busy = b; lastTopBit = l; arrayData = d;
    #1;
    checkAll();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b;
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    #1;
    chk(doutEn == 1'b0 && dout == '0, "R2 reset state", {doutEn, dout}, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R9: first read after reset while busy returns 1
    drive(1, 1, 1, 1, 1, 0, 8'h00);
    drive(1, 0, 0, 1, 1, 0, 8'h00);
    chk(dout[6] == 1'b1, "R9 first toggle after reset", dout[6], 1);
    drive(1, 0, 0, 1, 1, 0, 8'h00); // R7 held read, same bit 6
    chk(dout[6] == 1'b1, "R7 held read", dout[6], 1);
    drive(1, 0, 1, 1, 1, 0, 8'h00);
    drive(1, 0, 0, 1, 1, 1, 8'hFF);
    chk(dout[6] == 1'b0, "R6 second read toggles", dout[6], 0);
    drive(1, 0, 1, 1, 1, 1, 8'hFF);
    drive(1, 0, 1, 1, 1, 1, 8'hFF); // idle clocks, no flip
    drive(1, 0, 1, 1, 1, 1, 8'hFF);
    drive(1, 0, 0, 1, 1, 1, 8'hFF);
    chk(dout[6] == 1'b1, "R6 idle clocks no flip", dout[6], 1);
    // R8: res low mid-read releases
    drive(0, 0, 0, 1, 1, 1, 8'hFF);
    chk(doutEn == 1'b0, "R8 res low", doutEn, 0);
    // R3: busy ends, true data
    drive(1, 0, 0, 1, 0, 1, 8'hA5);
    chk(dout == 8'hA5, "R3 after busy", dout, 8'hA5);
    drive(1, 1, 1, 1, 0, 0, 8'h00);
    // R5: new busy, first read returns 1
    drive(1, 1, 1, 1, 1, 0, 8'h00);
    drive(1, 0, 0, 1, 1, 0, 8'h3C);
    chk(dout[6] == 1'b1, "R5 first read of new cycle", dout[6], 1);
    // R1: write low blocks drive
    drive(1, 0, 0, 0, 1, 0, 8'h3C);
    chk(doutEn == 1'b0, "R1 write low", doutEn, 0);
    // random phase
    b = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 40) == 0) b = ~b;
      drive($urandom_range(0, 15) != 0, $urandom_range(0, 3) == 0,
            $urandom_range(0, 1) == 0, $urandom_range(0, 7) != 0,
            b, 1'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule